// File: doc/BRIEF.md
# Floating-Point Operand Conditioner and NaN Resolver

This block sits at the front of a floating-point arithmetic pipe. It takes two raw operands and a format select (half, single or double precision). It returns the operands after denormal flushing, together with the NaN outcome of the operation they feed. Control inputs choose the behaviour: a general flush-to-zero bit, a half-precision flush bit, an input-flush bit, a default-NaN bit and an alternate-handling bit. A per-operation exemption input marks absolute-value and negate operations, which must see their operands untouched.

All decisions are made in one combinational pass. The results land in an output register one cycle after the input is presented. Downstream arithmetic consumes the conditioned operands. When `nan_valid` is high, it replaces its own result with `nan_res` and merges the two event flags into its exception state.

Format encoding on `fmt`: 0 = half (bits [15:0]), 1 = single (bits [31:0]), 2 = double (bits [63:0]). The value 3 behaves as double. Bits above the selected width are ignored on input and are zero on every data output.

Top module: `fpin_nan_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, every output is zero.
- R2: `out_valid` equals `in_valid` delayed by one clock. When `out_valid` is low, `nan_valid`, `denorm_evt` and `invalid_evt` are low and `nan_res` is zero.
- R3: With `ctl_fiz` = 1, a single or double denormal operand (exponent zero, fraction non-zero) is output as a zero with its sign kept, unless `exempt` = 1. Such a flush raises `denorm_evt` only when `ctl_fz` = 1 and `ctl_ah` = 0.
- R4: With `ctl_fz` = 1 and `ctl_ah` = 0, single and double denormal operands are flushed to signed zero and `denorm_evt` is raised. With `ctl_ah` = 1 and `ctl_fiz` = 0, `ctl_fz` leaves the inputs unflushed.
- R5: Half-precision operands are flushed only by `ctl_fz16`, never by `ctl_fz` or `ctl_fiz`, and a half-precision flush never raises `denorm_evt`.
- R6: With no flush control active, or for operands that are not denormal, the conditioned outputs equal the inputs masked to the format width.
- R7: With `ctl_dn` = 0 and `ctl_ah` = 0, the NaN chosen is the first signalling NaN of (a, b), else the first quiet NaN of (a, b). It is output with its top fraction bit (bit 9 / 22 / 51) set.
- R8: With `ctl_dn` = 1 and `ctl_ah` = 0, any NaN operand gives the default NaN: 0x7E00, 0x7FC00000 or 0x7FF8000000000000 for half, single and double.
- R9: With `ctl_ah` = 1, the default NaN has its sign bit set (0xFE00, 0xFFC00000, 0xFFF8000000000000). With `ctl_dn` = 0, a NaN in operand a is chosen over any NaN in b, whatever their signalling state.
- R10: `invalid_evt` is raised whenever either operand is a signalling NaN (all-ones exponent, top fraction bit 0, fraction non-zero), under any control setting.
- R11: `nan_valid` is high only when at least one operand is a NaN. Infinities and numbers give `nan_valid` = 0 and `nan_res` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| fmt | input | 2 | Precision select: 0 half, 1 single, 2 double |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| ctl_fz | input | 1 | Flush-to-zero for single and double |
| ctl_fz16 | input | 1 | Flush-to-zero for half precision |
| ctl_fiz | input | 1 | Flush denormal inputs for single and double |
| ctl_dn | input | 1 | Default-NaN mode |
| ctl_ah | input | 1 | Alternate handling |
| exempt | input | 1 | Operation is absolute value or negate; skip flushing |
| out_valid | output | 1 | Registered outputs are valid |
| a_out | output | 64 | Conditioned first operand |
| b_out | output | 64 | Conditioned second operand |
| nan_valid | output | 1 | The result is decided by NaN handling |
| nan_res | output | 64 | NaN result, zero when `nan_valid` is low |
| denorm_evt | output | 1 | Input-denormal event |
| invalid_evt | output | 1 | Invalid-operation event |

## Verification
The block holds no state beyond its output register, so any fault shows at the ports in the cycle right after the stimulus that exposes it. A wrong priority branch or quieting mask gives a NaN payload or sign that differs from the one computed from the operands. A wrong flush condition shows as a denormal passing through, or as a zero with the wrong sign or event. The bench walks each control combination that changes the selected path, with operands whose payloads make every choice visible.

// File: rtl/fpin_pkg.sv
package fpin_pkg;

    localparam int DW   = 64;
    localparam int H_EW = 5;
    localparam int H_FW = 10;
    localparam int S_EW = 8;
    localparam int S_FW = 23;
    localparam int D_EW = 11;
    localparam int D_FW = 52;
    localparam int H_W  = 1 + H_EW + H_FW;
    localparam int S_W  = 1 + S_EW + S_FW;
    localparam int D_W  = 1 + D_EW + D_FW;
    localparam int LANES = 2;

    typedef enum logic [1:0] {
        FMT_H   = 2'd0,
        FMT_S   = 2'd1,
        FMT_D   = 2'd2,
        FMT_RSV = 2'd3
    } fmt_e;

    typedef struct packed {
        logic fz;
        logic fz16;
        logic fiz;
        logic dn;
        logic ah;
    } ctl_t;

    typedef struct packed {
        logic nan;
        logic snan;
        logic qnan;
        logic denorm;
    } cls_t;

    function automatic logic [DW-1:0] ones_below(int n);
        return (DW'(1) << n) - DW'(1);
    endfunction

    function automatic logic [DW-1:0] width_mask(fmt_e f);
        case (f)
            FMT_H:   return ones_below(H_W);
            FMT_S:   return ones_below(S_W);
            default: return {DW{1'b1}};
        endcase
    endfunction

    function automatic logic [DW-1:0] frac_mask(fmt_e f);
        case (f)
            FMT_H:   return ones_below(H_FW);
            FMT_S:   return ones_below(S_FW);
            default: return ones_below(D_FW);
        endcase
    endfunction

    function automatic logic [DW-1:0] exp_mask(fmt_e f);
        case (f)
            FMT_H:   return ones_below(H_EW) << H_FW;
            FMT_S:   return ones_below(S_EW) << S_FW;
            default: return ones_below(D_EW) << D_FW;
        endcase
    endfunction

    function automatic logic [DW-1:0] sign_mask(fmt_e f);
        case (f)
            FMT_H:   return DW'(1) << (H_W - 1);
            FMT_S:   return DW'(1) << (S_W - 1);
            default: return DW'(1) << (D_W - 1);
        endcase
    endfunction

    function automatic logic [DW-1:0] quiet_mask(fmt_e f);
        case (f)
            FMT_H:   return DW'(1) << (H_FW - 1);
            FMT_S:   return DW'(1) << (S_FW - 1);
            default: return DW'(1) << (D_FW - 1);
        endcase
    endfunction

    function automatic logic [DW-1:0] default_nan(fmt_e f, logic neg);
        return exp_mask(f) | quiet_mask(f) | (neg ? sign_mask(f) : '0);
    endfunction

endpackage

// File: rtl/fpin_lane.sv
module fpin_lane
    import fpin_pkg::*;
(
    input  fmt_e          fmt,
    input  logic [DW-1:0] val,
    input  ctl_t          ctl,
    input  logic          exempt,
    output cls_t          cls,
    output logic [DW-1:0] cond,
    output logic          den_evt
);

    logic [DW-1:0] masked;
    logic [DW-1:0] exp_f;
    logic [DW-1:0] frac_f;
    logic          exp_max;
    logic          exp_zero;
    logic          frac_nz;
    logic          quiet;
    logic          is_half;
    logic          flush_en;
    logic          do_flush;

    always_comb begin
        masked   = val & width_mask(fmt);
        exp_f    = masked & exp_mask(fmt);
        frac_f   = masked & frac_mask(fmt);
        exp_max  = (exp_f == exp_mask(fmt));
        exp_zero = (exp_f == '0);
        frac_nz  = |frac_f;
        quiet    = |(masked & quiet_mask(fmt));

        cls.nan    = exp_max && frac_nz;
        cls.snan   = exp_max && frac_nz && !quiet;
        cls.qnan   = exp_max && quiet;
        cls.denorm = exp_zero && frac_nz;

        is_half  = (fmt == FMT_H);
        // half uses its own flush bit; wider formats flush on the input bit or on FZ without AH
        if (is_half) begin
            flush_en = ctl.fz16;
        end else begin
            flush_en = ctl.fiz || (ctl.fz && !ctl.ah);
        end
        do_flush = flush_en && !exempt && cls.denorm;

        cond    = do_flush ? (masked & sign_mask(fmt)) : masked;
        den_evt = do_flush && !is_half && ctl.fz && !ctl.ah;
    end

endmodule

// File: rtl/fpin_nan_pick.sv
module fpin_nan_pick
    import fpin_pkg::*;
(
    input  fmt_e          fmt,
    input  ctl_t          ctl,
    input  cls_t          a_cls,
    input  cls_t          b_cls,
    input  logic [DW-1:0] a_val,
    input  logic [DW-1:0] b_val,
    output logic          nan_hit,
    output logic          inv,
    output logic [DW-1:0] res
);

    logic          take_b;
    logic [DW-1:0] prop;

    always_comb begin
        nan_hit = a_cls.nan || b_cls.nan;
        inv     = a_cls.snan || b_cls.snan;

        if (ctl.ah) begin
            take_b = !a_cls.nan;
        end else if (a_cls.snan) begin
            take_b = 1'b0;
        end else if (b_cls.snan) begin
            take_b = 1'b1;
        end else begin
            take_b = !a_cls.qnan;
        end

        prop = (take_b ? b_val : a_val) | quiet_mask(fmt);

        if (!nan_hit) begin
            res = '0;
        end else if (ctl.dn) begin
            res = default_nan(fmt, ctl.ah);
        end else begin
            res = prop;
        end
    end

endmodule

// File: rtl/fpin_nan_unit.sv
module fpin_nan_unit
    import fpin_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [1:0]  fmt,
    input  logic [63:0] op_a,
    input  logic [63:0] op_b,
    input  logic        ctl_fz,
    input  logic        ctl_fz16,
    input  logic        ctl_fiz,
    input  logic        ctl_dn,
    input  logic        ctl_ah,
    input  logic        exempt,
    output logic        out_valid,
    output logic [63:0] a_out,
    output logic [63:0] b_out,
    output logic        nan_valid,
    output logic [63:0] nan_res,
    output logic        denorm_evt,
    output logic        invalid_evt
);

    fmt_e          fmt_q;
    ctl_t          ctl;
    logic [DW-1:0] lane_in  [LANES];
    logic [DW-1:0] lane_out [LANES];
    cls_t          lane_cls [LANES];
    logic          lane_evt [LANES];
    logic          nan_hit;
    logic          inv_c;
    logic [DW-1:0] res_c;
    logic          evt_any;

    assign fmt_q      = fmt_e'(fmt);
    assign ctl        = '{fz: ctl_fz, fz16: ctl_fz16, fiz: ctl_fiz, dn: ctl_dn, ah: ctl_ah};
    assign lane_in[0] = op_a;
    assign lane_in[1] = op_b;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        fpin_lane lane_i (
            .fmt     (fmt_q),
            .val     (lane_in[i]),
            .ctl     (ctl),
            .exempt  (exempt),
            .cls     (lane_cls[i]),
            .cond    (lane_out[i]),
            .den_evt (lane_evt[i])
        );
    end

    fpin_nan_pick pick_i (
        .fmt     (fmt_q),
        .ctl     (ctl),
        .a_cls   (lane_cls[0]),
        .b_cls   (lane_cls[1]),
        .a_val   (lane_out[0]),
        .b_val   (lane_out[1]),
        .nan_hit (nan_hit),
        .inv     (inv_c),
        .res     (res_c)
    );

    assign evt_any = lane_evt[0] || lane_evt[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            a_out       <= '0;
            b_out       <= '0;
            nan_valid   <= 1'b0;
            nan_res     <= '0;
            denorm_evt  <= 1'b0;
            invalid_evt <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            a_out       <= lane_out[0];
            b_out       <= lane_out[1];
            nan_valid   <= in_valid && nan_hit;
            nan_res     <= (in_valid && nan_hit) ? res_c : '0;
            denorm_evt  <= in_valid && evt_any;
            invalid_evt <= in_valid && inv_c;
        end
    end

endmodule

// File: rtl/fpin_nan_unit_chk.sv
module fpin_nan_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [1:0]  fmt,
    input logic [63:0] op_a,
    input logic        ctl_dn,
    input logic        ctl_ah,
    input logic        out_valid,
    input logic [63:0] a_out,
    input logic        nan_valid,
    input logic [63:0] nan_res,
    input logic        denorm_evt,
    input logic        invalid_evt
);

    logic a_is_snan_s;
    logic a_is_nan_d;
    assign a_is_snan_s = (op_a[30:23] == 8'hFF) && !op_a[22] && (op_a[21:0] != '0);
    assign a_is_nan_d  = (op_a[62:52] == 11'h7FF) && (op_a[51:0] != '0);

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && !nan_valid && !denorm_evt && !invalid_evt && a_out == '0));

    a_r2_valid_follow: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r2_valid_drop: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r2_flags_gated: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!nan_valid && !denorm_evt && !invalid_evt));

    a_r5_half_no_event: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fmt == 2'd0) |=> !denorm_evt);

    a_r8_default_double: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fmt == 2'd2 && ctl_dn && !ctl_ah && a_is_nan_d)
            |=> (nan_valid && nan_res == 64'h7FF8_0000_0000_0000));

    a_r10_snan_invalid: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fmt == 2'd1 && a_is_snan_s) |=> (invalid_evt && nan_valid));

    a_r11_res_zero: assert property (@(posedge clk) disable iff (rst)
        !nan_valid |-> (nan_res == '0));

endmodule

bind fpin_nan_unit fpin_nan_unit_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .fmt         (fmt),
    .op_a        (op_a),
    .ctl_dn      (ctl_dn),
    .ctl_ah      (ctl_ah),
    .out_valid   (out_valid),
    .a_out       (a_out),
    .nan_valid   (nan_valid),
    .nan_res     (nan_res),
    .denorm_evt  (denorm_evt),
    .invalid_evt (invalid_evt)
);

// File: tb/fpin_nan_unit_tb_top.sv
module fpin_nan_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  fmt = 2'd0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        ctl_fz = 1'b0, ctl_fz16 = 1'b0, ctl_fiz = 1'b0, ctl_dn = 1'b0, ctl_ah = 1'b0;
    logic        exempt = 1'b0;
    logic        out_valid, nan_valid, denorm_evt, invalid_evt;
    logic [63:0] a_out, b_out, nan_res;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    fpin_nan_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .fmt(fmt),
        .op_a(op_a), .op_b(op_b), .ctl_fz(ctl_fz), .ctl_fz16(ctl_fz16),
        .ctl_fiz(ctl_fiz), .ctl_dn(ctl_dn), .ctl_ah(ctl_ah), .exempt(exempt),
        .out_valid(out_valid), .a_out(a_out), .b_out(b_out),
        .nan_valid(nan_valid), .nan_res(nan_res),
        .denorm_evt(denorm_evt), .invalid_evt(invalid_evt)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // controls are {fz, fz16, fiz, dn, ah}
    task automatic drive(logic v, logic [1:0] f, logic [63:0] a, logic [63:0] b,
                         logic [4:0] c, logic ex);
        @(negedge clk);
        in_valid = v; fmt = f; op_a = a; op_b = b; exempt = ex;
        {ctl_fz, ctl_fz16, ctl_fiz, ctl_dn, ctl_ah} = c;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        chk("R1 out_valid", 64'(out_valid), 0);
        chk("R1 a_out", a_out, 0);
        chk("R1 nan_res", nan_res, 0);
        chk("R1 events", {62'd0, denorm_evt, invalid_evt}, 0);
    endtask

    task automatic t_passthrough;
        drive(1, 2'd1, 64'hDEAD_BEEF_3F80_0000, 64'h1234_5678_4000_0000, 5'b00000, 0);
        chk("R6 a_out single masked", a_out, 64'h3F80_0000);
        chk("R6 b_out single masked", b_out, 64'h4000_0000);
        chk("R2 out_valid", 64'(out_valid), 1);
        chk("R11 no nan", 64'(nan_valid), 0);
        drive(1, 2'd1, 64'h0000_0010, 0, 5'b00000, 0);
        chk("R6 denormal kept", a_out, 64'h10);
        drive(1, 2'd1, 64'h7F80_0000, 64'hFF80_0000, 5'b00000, 0);
        chk("R11 infinity not nan", 64'(nan_valid), 0);
        chk("R11 nan_res zero", nan_res, 0);
    endtask

    task automatic t_fiz;
        drive(1, 2'd2, 64'h8000_0000_0000_0001, 0, 5'b00100, 0);
        chk("R3 fiz flush keeps sign", a_out, 64'h8000_0000_0000_0000);
        chk("R3 no event fz=0", 64'(denorm_evt), 0);
        drive(1, 2'd2, 64'h8000_0000_0000_0001, 0, 5'b00100, 1);
        chk("R3 exempt unflushed", a_out, 64'h8000_0000_0000_0001);
        drive(1, 2'd2, 64'h0000_0000_0000_0003, 0, 5'b10101, 0);
        chk("R3 fiz ah flush", a_out, 0);
        chk("R3 no event ah=1", 64'(denorm_evt), 0);
        drive(1, 2'd1, 0, 64'h8000_0001, 5'b10100, 0);
        chk("R3 fiz fz event", 64'(denorm_evt), 1);
        chk("R3 b flushed", b_out, 64'h8000_0000);
    endtask

    task automatic t_fz;
        drive(1, 2'd1, 64'h0000_0010, 64'h3F80_0000, 5'b10000, 0);
        chk("R4 fz flush", a_out, 0);
        chk("R4 fz event", 64'(denorm_evt), 1);
        chk("R4 normal kept", b_out, 64'h3F80_0000);
        drive(1, 2'd1, 64'h0000_0010, 0, 5'b10001, 0);
        chk("R4 ah blocks fz flush", a_out, 64'h10);
        chk("R4 ah no event", 64'(denorm_evt), 0);
    endtask

    task automatic t_half;
        drive(1, 2'd0, 64'h8001, 0, 5'b10100, 0);
        chk("R5 fz fiz ignore half", a_out, 64'h8001);
        chk("R5 no event", 64'(denorm_evt), 0);
        drive(1, 2'd0, 64'hFFFF_0000_0000_8001, 0, 5'b11000, 0);
        chk("R5 fz16 flush", a_out, 64'h8000);
        chk("R5 fz16 no event", 64'(denorm_evt), 0);
    endtask

    task automatic t_priority;
        drive(1, 2'd1, 64'h7FC0_0001, 64'h7F80_0002, 5'b00000, 0);
        chk("R7 snan b beats qnan a", nan_res, 64'h7FC0_0002);
        chk("R10 invalid b", 64'(invalid_evt), 1);
        drive(1, 2'd1, 64'h7F80_0005, 64'h7F80_0006, 5'b00000, 0);
        chk("R7 snan a first", nan_res, 64'h7FC0_0005);
        drive(1, 2'd1, 64'h3F80_0000, 64'hFFC0_0003, 5'b00000, 0);
        chk("R7 qnan b", nan_res, 64'hFFC0_0003);
        chk("R10 no invalid", 64'(invalid_evt), 0);
        chk("R11 nan_valid", 64'(nan_valid), 1);
        drive(1, 2'd0, 64'h7C01, 64'h3C00, 5'b00000, 0);
        chk("R7 half quieted", nan_res, 64'h7E01);
        drive(1, 2'd2, 64'h7FF8_0000_0000_0007, 64'h7FF8_0000_0000_0009, 5'b00000, 0);
        chk("R7 qnan a over qnan b", nan_res, 64'h7FF8_0000_0000_0007);
    endtask

    task automatic t_default;
        drive(1, 2'd2, 64'h3FF0_0000_0000_0000, 64'h7FF8_0000_0000_0001, 5'b00010, 0);
        chk("R8 double default", nan_res, 64'h7FF8_0000_0000_0000);
        drive(1, 2'd0, 64'h7D00, 0, 5'b00010, 0);
        chk("R8 half default", nan_res, 64'h7E00);
        chk("R10 invalid under dn", 64'(invalid_evt), 1);
        drive(1, 2'd1, 64'hFFC0_0009, 0, 5'b00010, 0);
        chk("R8 single default", nan_res, 64'h7FC0_0000);
    endtask

    task automatic t_alt;
        drive(1, 2'd1, 64'h7FC0_0001, 64'h7F80_0002, 5'b00001, 0);
        chk("R9 ah first operand", nan_res, 64'h7FC0_0001);
        chk("R10 invalid ah", 64'(invalid_evt), 1);
        drive(1, 2'd1, 64'h7FC0_0001, 0, 5'b00011, 0);
        chk("R9 ah default single", nan_res, 64'hFFC0_0000);
        drive(1, 2'd2, 0, 64'h7FF0_0000_0000_0001, 5'b00011, 0);
        chk("R9 ah default double", nan_res, 64'hFFF8_0000_0000_0000);
        drive(1, 2'd1, 64'h3F80_0000, 64'h7F80_0004, 5'b00001, 0);
        chk("R9 ah b when a number", nan_res, 64'h7FC0_0004);
    endtask

    task automatic t_idle;
        drive(0, 2'd1, 64'h7F80_0001, 0, 5'b10100, 0);
        chk("R2 out_valid low", 64'(out_valid), 0);
        chk("R2 invalid gated", 64'(invalid_evt), 0);
        chk("R2 nan_res gated", nan_res, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        t_reset();
        t_passthrough();
        t_fiz();
        t_fz();
        t_half();
        t_priority();
        t_default();
        t_alt();
        t_idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule